// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from four device groups and presents one interrupt line and a short vector code to a processor. Each group owns a request/acknowledge pair and a fixed level, group `g` sitting at level `g+1`, so group 3 is the most urgent. Inside a group every device has its own request bit. The group line is the OR of those bits. The group acknowledge ripples from the device nearest the controller (position 0) outward, and the first device that is requesting takes it.

The controller keeps a small processor status: an interrupt-enable bit and a 3-bit current priority, where 0 is the lowest. A request is offered only when interrupts are enabled and its level is strictly above the current priority. On acceptance the current status is pushed onto an internal LIFO of depth four. The priority then rises to the accepted level and the enable bit clears. A return-from-interrupt pops the saved status back, so nested service unwinds in order. Software may overwrite the status directly. Each group can be switched into edge mode, where one rising edge of a device line yields exactly one request.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is held, and right after it, `cpu_irq`, `grp_ack` and `dev_ack` are 0, `int_en` is 1 and `cur_prio` is 0.
- R2: `cpu_irq` is 1 only when `int_en` is 1 and the level of the highest pending group (group g has level g+1) is strictly greater than `cur_prio`; an equal level does not interrupt.
- R3: When several groups are pending, the one with the highest index wins. While `cpu_irq` is 1, `irq_vec` equals {4'hA, group index (2 bits), chain position (2 bits)}, with bits 7:4 = 4'hA, bits 3:2 = group and bits 1:0 = position; it is 0 otherwise.
- R4: In a cycle with `cpu_ack` and `cpu_irq` both 1, `grp_ack` has exactly the winning group's bit set. `dev_ack` has exactly bit g*4+p set, where p is the lowest requesting position in that group (the position nearest the controller).
- R5: The clock edge that ends an acknowledged cycle sets `cur_prio` to the accepted level and clears `int_en`.
- R6: `cpu_reti` restores the `int_en`/`cur_prio` pair saved by the most recent unreturned acceptance. It has no effect when nothing is saved. While four acceptances are unreturned, `cpu_irq` stays 0.
- R7: With `trig_edge[g]` = 1, a device of group g raises one request per rising edge of its line: the request persists after the line drops and is not raised again while the line stays high after service. With `trig_edge[g]` = 0, the request follows the line.
- R8: `st_we` loads `st_wen` and `st_wprio` into `int_en` and `cur_prio` on the next edge, provided no acceptance or return happens in that cycle.
- R9: `cpu_ack` while `cpu_irq` is 0 drives no acknowledge and leaves `int_en` and `cur_prio` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dev_req | input | 16 | Device request bits, bit g*4+p = group g, chain position p |
| trig_edge | input | 4 | Per-group edge mode select |
| cpu_ack | input | 1 | Processor takes the offered interrupt |
| cpu_reti | input | 1 | Return from interrupt, restores saved status |
| st_we | input | 1 | Status write strobe |
| st_wen | input | 1 | Enable value to write |
| st_wprio | input | 3 | Priority value to write |
| cpu_irq | output | 1 | Interrupt request to the processor |
| irq_vec | output | 8 | Vector code of the winning device |
| grp_ack | output | 4 | Per-group acknowledge lines |
| dev_ack | output | 16 | Per-device acknowledge after the daisy chain |
| int_en | output | 1 | Interrupt-enable bit |
| cur_prio | output | 3 | Current processor priority |

## Verification
The hardest state to reach is a full save stack. It needs four nested acceptances, and each one clears the enable bit and raises the priority, which would block the next. The stimulus reaches it by rewriting the status to enable 1 and priority 0 before each acceptance while a group-0 device holds its line. The check is that the still-pending request is withheld and comes back after one return. A second hard case is the edge mode after service: the line is held high through acknowledge and return, and the request must not come back until the line falls and rises again.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  parameter int DEF_GROUPS = 4;
  parameter int DEF_CHAIN  = 4;
  parameter logic [3:0] DEF_VEC_BASE = 4'hA;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] edge_sel,
  input  logic [N-1:0] ack,
  output logic [N-1:0] pend
);
  logic [N-1:0] req_q, hit_q, hit_d, rise;

  always_comb begin
    rise  = req & ~req_q;
    hit_d = rise | (hit_q & ~ack);
    pend  = (edge_sel & hit_q) | (~edge_sel & req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      hit_q <= '0;
    end else begin
      req_q <= req;
      hit_q <= hit_d;
    end
  end
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain #(
  parameter int CHAIN = 4,
  localparam int CW = (CHAIN > 1) ? $clog2(CHAIN) : 1
) (
  input  logic             ack_in,
  input  logic [CHAIN-1:0] pend,
  output logic [CHAIN-1:0] ack_out,
  output logic [CW-1:0]    first_pos
);
  logic [CHAIN:0] pass;
  assign pass[0] = ack_in;

  for (genvar i = 0; i < CHAIN; i++) begin : g_link
    assign ack_out[i]  = pass[i] & pend[i];
    assign pass[i+1]   = pass[i] & ~pend[i];
  end

  always_comb begin
    first_pos = '0;
    for (int i = CHAIN - 1; i >= 0; i--) begin
      if (pend[i]) first_pos = CW'(i);
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NGRP = 4,
  localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic [NGRP-1:0] grp_pend,
  output logic            any,
  output logic [GW-1:0]   win
);
  always_comb begin
    any = |grp_pend;
    win = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_pend[g]) win = GW'(g);
    end
  end
endmodule

// File: rtl/irq_save_stack.sv
module irq_save_stack #(
  parameter int W     = 4,
  parameter int DEPTH = 4,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]   mem [DEPTH];
  logic [SPW-1:0] sp_q, sp_d;
  logic           sp_ce;

  assign empty = (sp_q == '0);
  assign full  = (sp_q == SPW'(DEPTH));
  assign top   = empty ? '0 : mem[sp_q - SPW'(1)];

  always_comb begin
    sp_ce = (push && !full) || (pop && !empty);
    sp_d  = sp_q;
    if (push && !full)       sp_d = sp_q + SPW'(1);
    else if (pop && !empty)  sp_d = sp_q - SPW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '0;
    else if (sp_ce) sp_q <= sp_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !full && (sp_q == SPW'(i))) mem[i] <= din;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NGRP  = prio_irq_pkg::DEF_GROUPS,
  parameter int CHAIN = prio_irq_pkg::DEF_CHAIN,
  parameter logic [3:0] VEC_BASE = prio_irq_pkg::DEF_VEC_BASE,
  localparam int NDEV = NGRP * CHAIN,
  localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int CW   = (CHAIN > 1) ? $clog2(CHAIN) : 1,
  localparam int PW   = $clog2(NGRP + 1),
  localparam int VW   = 4 + GW + CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDEV-1:0] dev_req,
  input  logic [NGRP-1:0] trig_edge,
  input  logic            cpu_ack,
  input  logic            cpu_reti,
  input  logic            st_we,
  input  logic            st_wen,
  input  logic [PW-1:0]   st_wprio,
  output logic            cpu_irq,
  output logic [VW-1:0]   irq_vec,
  output logic [NGRP-1:0] grp_ack,
  output logic [NDEV-1:0] dev_ack,
  output logic            int_en,
  output logic [PW-1:0]   cur_prio
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  // request capture
  logic [NDEV-1:0] edge_dev, pend;
  for (genvar d = 0; d < NDEV; d++) begin : g_esel
    assign edge_dev[d] = trig_edge[d / CHAIN];
  end

  irq_req_latch #(.N(NDEV)) u_latch (
    .clk(clk), .rst_n(rst_s_n), .req(dev_req), .edge_sel(edge_dev),
    .ack(dev_ack), .pend(pend)
  );

  // group lines and daisy chains
  logic [NGRP-1:0] grp_pend;
  logic [CW-1:0]   grp_pos [NGRP];
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_pend[g] = |pend[g*CHAIN +: CHAIN];
    irq_daisy_chain #(.CHAIN(CHAIN)) u_chain (
      .ack_in(grp_ack[g]), .pend(pend[g*CHAIN +: CHAIN]),
      .ack_out(dev_ack[g*CHAIN +: CHAIN]), .first_pos(grp_pos[g])
    );
  end

  logic          any_pend;
  logic [GW-1:0] win_g;
  irq_prio_pick #(.NGRP(NGRP)) u_pick (
    .grp_pend(grp_pend), .any(any_pend), .win(win_g)
  );

  // status and save stack
  logic          en_q, en_d;
  logic [PW-1:0] prio_q, prio_d;
  logic          st_ce, accept, do_pop, stk_empty, stk_full;
  logic [PW:0]   stk_top;
  logic [PW-1:0] win_lvl;

  assign win_lvl = PW'(win_g) + PW'(1);
  assign cpu_irq = en_q && any_pend && !stk_full && (win_lvl > prio_q);
  assign accept  = cpu_ack && cpu_irq;
  assign do_pop  = cpu_reti && !stk_empty && !accept;

  irq_save_stack #(.W(PW + 1), .DEPTH(NGRP)) u_stack (
    .clk(clk), .rst_n(rst_s_n), .push(accept), .pop(do_pop),
    .din({en_q, prio_q}), .top(stk_top), .empty(stk_empty), .full(stk_full)
  );

  always_comb begin
    st_ce  = accept || do_pop || st_we;
    en_d   = en_q;
    prio_d = prio_q;
    if (accept) begin
      en_d   = 1'b0;
      prio_d = win_lvl;
    end else if (do_pop) begin
      {en_d, prio_d} = stk_top;
    end else if (st_we) begin
      en_d   = st_wen;
      prio_d = st_wprio;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      en_q   <= 1'b1;
      prio_q <= '0;
    end else if (st_ce) begin
      en_q   <= en_d;
      prio_q <= prio_d;
    end
  end

  // acknowledge routing and vector
  for (genvar g = 0; g < NGRP; g++) begin : g_gack
    assign grp_ack[g] = accept && (win_g == GW'(g));
  end

  assign irq_vec  = cpu_irq ? {VEC_BASE, win_g, grp_pos[win_g]} : '0;
  assign int_en   = en_q;
  assign cur_prio = prio_q;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int NGRP  = 4,
  parameter int CHAIN = 4,
  parameter logic [3:0] VEC_BASE = 4'hA,
  localparam int NDEV = NGRP * CHAIN,
  localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int CW   = (CHAIN > 1) ? $clog2(CHAIN) : 1,
  localparam int PW   = $clog2(NGRP + 1),
  localparam int VW   = 4 + GW + CW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_ack,
  input logic            cpu_irq,
  input logic [VW-1:0]   irq_vec,
  input logic [NGRP-1:0] grp_ack,
  input logic [NDEV-1:0] dev_ack,
  input logic            int_en,
  input logic [PW-1:0]   cur_prio
);
  // R2
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> int_en);

  // R3
  vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (irq_vec[VW-1 -: 4] == VEC_BASE));

  // R4
  grp_ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_ack) && $onehot0(dev_ack));

  // R4
  dev_follows_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grp_ack) |-> ($countones(dev_ack) == 1));

  // R9
  ack_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grp_ack) || (|dev_ack)) |-> (cpu_ack && cpu_irq));

  // R5
  accept_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_irq) |=> (!int_en && (cur_prio > $past(cur_prio))));
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NGRP(NGRP), .CHAIN(CHAIN), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ack(cpu_ack), .cpu_irq(cpu_irq),
  .irq_vec(irq_vec), .grp_ack(grp_ack), .dev_ack(dev_ack),
  .int_en(int_en), .cur_prio(cur_prio)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] dev_req = '0;
  logic [3:0]  trig_edge = '0;
  logic        cpu_ack = 1'b0, cpu_reti = 1'b0, st_we = 1'b0, st_wen = 1'b0;
  logic [2:0]  st_wprio = '0;
  logic        cpu_irq, int_en;
  logic [7:0]  irq_vec;
  logic [3:0]  grp_ack;
  logic [15:0] dev_ack;
  logic [2:0]  cur_prio;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .trig_edge(trig_edge),
    .cpu_ack(cpu_ack), .cpu_reti(cpu_reti), .st_we(st_we), .st_wen(st_wen),
    .st_wprio(st_wprio), .cpu_irq(cpu_irq), .irq_vec(irq_vec),
    .grp_ack(grp_ack), .dev_ack(dev_ack), .int_en(int_en), .cur_prio(cur_prio)
  );

  // {dev_req[15:0], prio[2:0], exp_irq, exp_vec[7:0]}
  localparam int NV = 8;
  localparam logic [27:0] TBL [NV] = '{
    {16'h0001, 3'd0, 1'b1, 8'hA0},
    {16'h0001, 3'd1, 1'b0, 8'h00},
    {16'h0060, 3'd0, 1'b1, 8'hA5},
    {16'h8001, 3'd2, 1'b1, 8'hAF},
    {16'h8001, 3'd4, 1'b0, 8'h00},
    {16'h0C00, 3'd2, 1'b1, 8'hAA},
    {16'h0000, 3'd0, 1'b0, 8'h00},
    {16'h0110, 3'd0, 1'b1, 8'hA8}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_reset(input logic [3:0] te);
    nxt();
    rst_n = 1'b0; dev_req = '0; trig_edge = te;
    cpu_ack = 0; cpu_reti = 0; st_we = 0;
    repeat (2) nxt();
    rst_n = 1'b1;
    repeat (3) nxt();
  endtask

  task automatic wr_status(input logic en, input logic [2:0] p);
    st_we = 1; st_wen = en; st_wprio = p;
    nxt();
    st_we = 0;
  endtask

  task automatic pulse_reti();
    cpu_reti = 1;
    nxt();
    cpu_reti = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) nxt();
    settle();
    chk(cpu_irq == 0 && grp_ack == 0 && dev_ack == 0, "R1 outputs in reset", {cpu_irq, grp_ack, dev_ack}, 0);
    chk(int_en == 1 && cur_prio == 0, "R1 status in reset", {int_en, cur_prio}, 4'h8);
    rst_n = 1'b1;
    repeat (3) nxt();
    settle();
    chk(int_en == 1 && cur_prio == 0 && cpu_irq == 0, "R1 status after release", {cpu_irq, int_en, cur_prio}, 4'h8);

    // table walk, level mode
    for (int k = 0; k < NV; k++) begin
      logic [15:0] rq = TBL[k][27:12];
      logic [2:0]  pr = TBL[k][11:9];
      logic        ei = TBL[k][8];
      logic [7:0]  ev = TBL[k][7:0];
      logic [1:0]  gg = ev[3:2];
      logic [1:0]  pp = ev[1:0];
      logic [3:0]  eg = ei ? (4'b1 << gg) : 4'b0;
      logic [15:0] ed = ei ? (16'b1 << (gg * 4 + pp)) : 16'b0;
      wr_status(1'b1, pr);
      dev_req = rq;
      nxt();
      settle();
      chk(cpu_irq == ei, $sformatf("R2 irq row %0d", k), cpu_irq, ei);
      chk(irq_vec == ev, $sformatf("R3 vector row %0d", k), irq_vec, ev);
      cpu_ack = 1;
      settle();
      chk(grp_ack == eg, $sformatf("R4 grp_ack row %0d", k), grp_ack, eg);
      chk(dev_ack == ed, $sformatf("R4 dev_ack row %0d", k), dev_ack, ed);
      nxt();
      cpu_ack = 0; dev_req = '0;
      settle();
      if (ei)
        chk(cur_prio == 3'(gg) + 3'd1 && int_en == 0, $sformatf("R5 accept row %0d", k),
            {int_en, cur_prio}, {1'b0, 3'(gg) + 3'd1});
      else
        chk(cur_prio == pr && int_en == 1, $sformatf("R9 ignored ack row %0d", k),
            {int_en, cur_prio}, {1'b1, pr});
      pulse_reti();
      settle();
      chk(cur_prio == pr && int_en == 1, $sformatf("R6 restore row %0d", k),
          {int_en, cur_prio}, {1'b1, pr});
    end

    // nesting with software re-enable
    do_reset(4'b0000);
    dev_req = 16'h0001;
    nxt(); settle();
    chk(cpu_irq == 1 && irq_vec == 8'hA0, "R2 nest first irq", irq_vec, 8'hA0);
    cpu_ack = 1;
    nxt(); cpu_ack = 0; dev_req = 16'h0101;
    settle();
    chk(int_en == 0 && cur_prio == 1, "R5 nest first accept", {int_en, cur_prio}, 4'h1);
    nxt(); settle();
    chk(cpu_irq == 0, "R2 disabled blocks higher group", cpu_irq, 0);
    wr_status(1'b1, 3'd1);
    settle();
    chk(int_en == 1 && cur_prio == 1, "R8 status write", {int_en, cur_prio}, 4'h9);
    chk(cpu_irq == 1 && irq_vec == 8'hA8, "R3 nested vector", irq_vec, 8'hA8);
    cpu_ack = 1;
    nxt(); cpu_ack = 0;
    settle();
    chk(int_en == 0 && cur_prio == 3, "R5 nested accept", {int_en, cur_prio}, 4'h3);
    pulse_reti(); settle();
    chk(int_en == 1 && cur_prio == 1, "R6 inner return", {int_en, cur_prio}, 4'h9);
    chk(cpu_irq == 1, "R7 level line re-requests", cpu_irq, 1);
    pulse_reti(); settle();
    chk(int_en == 1 && cur_prio == 0, "R6 outer return", {int_en, cur_prio}, 4'h8);
    pulse_reti(); settle();
    chk(int_en == 1 && cur_prio == 0, "R6 return with empty stack", {int_en, cur_prio}, 4'h8);
    dev_req = '0;

    // full save stack
    do_reset(4'b0000);
    dev_req = 16'h0001;
    for (int n = 0; n < 4; n++) begin
      wr_status(1'b1, 3'd0);
      cpu_ack = 1;
      nxt();
      cpu_ack = 0;
    end
    settle();
    chk(cur_prio == 1 && int_en == 0, "R5 fourth accept", {int_en, cur_prio}, 4'h1);
    wr_status(1'b1, 3'd0);
    settle();
    chk(cpu_irq == 0, "R6 full stack blocks irq", cpu_irq, 0);
    pulse_reti(); settle();
    chk(cpu_irq == 1 && int_en == 1 && cur_prio == 0, "R6 irq back after pop",
        {cpu_irq, int_en, cur_prio}, 5'h18);
    dev_req = '0;

    // edge mode on group 0
    do_reset(4'b0001);
    dev_req = 16'h0001;
    nxt(); settle();
    chk(cpu_irq == 1 && irq_vec == 8'hA0, "R7 edge request", irq_vec, 8'hA0);
    cpu_ack = 1;
    nxt(); cpu_ack = 0;
    pulse_reti(); settle();
    chk(int_en == 1 && cur_prio == 0, "R6 edge return", {int_en, cur_prio}, 4'h8);
    chk(cpu_irq == 0, "R7 held line not re-requested", cpu_irq, 0);
    dev_req = '0;
    nxt();
    dev_req = 16'h0001;
    nxt(); settle();
    chk(cpu_irq == 1, "R7 new edge requests", cpu_irq, 1);
    dev_req = '0;
    nxt(); settle();
    chk(cpu_irq == 1 && irq_vec == 8'hA0, "R7 request held after line drops", irq_vec, 8'hA0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule